// File: doc/BRIEF.md
# Indexed Operand Address Generator

This block turns one indexed-addressing postbyte into a 16-bit effective operand address for a small microcontroller core. The core hands it the postbyte, the current index registers (X, Y, SP, PC) and the two 8-bit accumulators, and pulses `start`. The block then works out which of five addressing classes the postbyte selects. Depending on the class, it fetches zero, one or two extension bytes from the instruction stream, may read a 16-bit pointer from memory, and finally pulses `done` with the address.

The classes are: a short signed offset held in the postbyte; auto pre/post increment or decrement of an index register; a 9-bit or 16-bit offset taken from the instruction stream; an accumulator offset; and two memory-indirect forms. For the auto forms the block returns the new register value and a write enable in the same cycle as `done`, so the core can update the register. It also reports how many instruction bytes it consumed and whether the form costs an extra cycle. A restricted-mode input suppresses the long-offset forms. All memory traffic goes over a simple byte request/acknowledge bus. The bus address is held until acknowledge, and instruction bytes are read at `reg_pc` and `reg_pc+1`.

Top module: `idx_addr_gen`

## Requirements
- R1: Postbyte bit 5 = 0 selects the short form: the register code is bits 7:6 (0=X, 1=Y, 2=SP, 3=PC), and the address is that register plus bits 4:0 read as two's complement (−16..+15), with no write-back, no bus access, no extension bytes and no extra cycle.
- R2: Bit 5 = 1 with bits 7:6 ≠ 11 selects an auto form on the register coded in bits 7:6. The step is bits 3:0: when bit 3 = 1 the step is the sign-extended value (−8..−1); when bit 3 = 0 the step is the field plus one (+1..+8). `wb_en` rises with `done`, `wb_sel` equals bits 7:6, and `wb_val` is register plus step.
- R3: In the auto forms, bit 4 = 0 returns the updated register value as the address (pre-modify), and bit 4 = 1 returns the old value (post-modify).
- R4: With bits 7:5 = 111, the register is coded by bits 4:3. If bit 2 = 0 and bits 1:0 = 00 or 01, one byte is fetched at `reg_pc`. That byte, extended with bit 0 as sign (a 9-bit offset), is added to the register. `ext_len` = 1 and `extra_cyc` = 1.
- R5: With bits 7:5 = 111 and bits 2:0 = 010, two bytes are fetched, the high byte at `reg_pc` and the low byte at `reg_pc+1`. They form a 16-bit offset added to the register. `ext_len` = 2 and `extra_cyc` = 1.
- R6: With bits 7:5 = 111 and bits 2:0 = 011, a 16-bit offset is fetched as in R5 and added to the register. The address is then the big-endian word read at that sum: high byte at the sum, low byte at sum+1. `ext_len` = 2 and `extra_cyc` = 1.
- R7: With bits 7:5 = 111 and bit 2 = 1, bits 1:0 = 00 adds A and 01 adds B (each zero-extended), and 10 adds D = {A,B}. There is no bus access and no extra cycle.
- R8: With bits 7:5 = 111 and bits 2:0 = 111, the address is the big-endian word read at register + D. `ext_len` = 0 and `extra_cyc` = 1.
- R9: When `restricted` = 1, the forms of R4, R5 and R6 return address 0 with no bus request, `ext_len` = 0 and `extra_cyc` = 0. All other forms are unaffected.
- R10: `done` is a one-cycle pulse. Forms without bus traffic raise it in the cycle after `start` is sampled. While `bus_req` waits for `bus_ack`, `bus_addr` stays stable.
- R11: All address, offset and step arithmetic wraps modulo 2^16.
- R12: After reset, `done`, `bus_req` and `wb_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin decoding `postbyte` (sampled when idle) |
| postbyte | input | 8 | Indexed-addressing postbyte |
| restricted | input | 1 | Suppress long-offset and offset-indirect forms |
| reg_x | input | AW | Index register X |
| reg_y | input | AW | Index register Y |
| reg_sp | input | AW | Stack pointer |
| reg_pc | input | AW | Address of first extension byte; also PC as index |
| acc_a | input | 8 | Accumulator A (high half of D) |
| acc_b | input | 8 | Accumulator B (low half of D) |
| bus_req | output | 1 | Byte read request |
| bus_addr | output | AW | Byte read address |
| bus_ack | input | 1 | Read data valid |
| bus_rdata | input | 8 | Read data |
| done | output | 1 | Address valid pulse |
| eff_addr | output | AW | Effective address |
| wb_en | output | 1 | Index register write-back enable (with `done`) |
| wb_sel | output | 2 | Register code to write |
| wb_val | output | AW | Value to write |
| ext_len | output | 2 | Instruction bytes consumed (valid with `done`) |
| extra_cyc | output | 1 | Form costs one extra cycle (valid with `done`) |

## Verification
The bench sweeps all 256 postbytes, with and without restricted mode, over register sets chosen so that sums cross 0xFFFF and negative offsets reach below zero. It also varies the acknowledge delay. Getting the auto-step encoding wrong (bit 3 clear giving +0..+7) or swapping the pre/post sense shows up as an off-by-one address or write-back value. Sign-extending A or B instead of zero-extending them gives a wrong address when an accumulator holds a value of 0x80 or above. Reading the indirect word little-endian, or fetching long-form bytes while restricted, shows up in the address and in the count of bus acknowledges per operation.

// File: rtl/idx_addr_gen.sv
module idx_addr_gen #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    postbyte,
  input  logic          restricted,
  input  logic [AW-1:0] reg_x,
  input  logic [AW-1:0] reg_y,
  input  logic [AW-1:0] reg_sp,
  input  logic [AW-1:0] reg_pc,
  input  logic [7:0]    acc_a,
  input  logic [7:0]    acc_b,
  output logic          bus_req,
  output logic [AW-1:0] bus_addr,
  input  logic          bus_ack,
  input  logic [7:0]    bus_rdata,
  output logic          done,
  output logic [AW-1:0] eff_addr,
  output logic          wb_en,
  output logic [1:0]    wb_sel,
  output logic [AW-1:0] wb_val,
  output logic [1:0]    ext_len,
  output logic          extra_cyc
);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_IND, S_FIN} st_t;

  st_t           st;
  logic [7:0]    pb;
  logic [AW-1:0] base, pc_q, sum, ea_q, wbv_q, old_q;
  logic [7:0]    hi;
  logic          idx, ind_q, wb_q, xc_q, blk_q;
  logic [1:0]    nf;

  wire       f_short = !postbyte[5];
  wire       f_auto  = postbyte[5] && (postbyte[7:6] != 2'b11);
  wire       f_ext   = (postbyte[7:5] == 3'b111);
  wire       f_ind16 = f_ext && (postbyte[2:0] == 3'd3);
  wire       f_off   = f_ext && !postbyte[2] && (postbyte[1:0] != 2'b11);
  wire [1:0] rsel    = f_ext ? postbyte[4:3] : postbyte[7:6];
  wire       blocked = restricted && (f_ind16 || f_off);

  logic [AW-1:0] base_in, acc_off;
  always_comb begin
    case (rsel)
      2'd0:    base_in = reg_x;
      2'd1:    base_in = reg_y;
      2'd2:    base_in = reg_sp;
      default: base_in = reg_pc;
    endcase
  end

  wire [AW-1:0] d_val = AW'({acc_a, acc_b});
  always_comb begin
    case (postbyte[1:0])
      2'd0:    acc_off = AW'(acc_a);
      2'd1:    acc_off = AW'(acc_b);
      default: acc_off = d_val;
    endcase
  end

  wire [AW-1:0] off5 = {{(AW-5){postbyte[4]}}, postbyte[4:0]};
  wire [AW-1:0] step = postbyte[3] ? {{(AW-4){1'b1}}, postbyte[3:0]}
                                   : AW'(postbyte[3:0]) + AW'(1);
  wire [AW-1:0] stepped = base_in + step;
  wire [AW-1:0] fetch_off = (nf == 2'd2) ? AW'({hi, bus_rdata})
                                         : {{(AW-8){pb[0]}}, bus_rdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      pb    <= '0;
      base  <= '0;
      pc_q  <= '0;
      sum   <= '0;
      ea_q  <= '0;
      wbv_q <= '0;
      old_q <= '0;
      hi    <= '0;
      idx   <= 1'b0;
      ind_q <= 1'b0;
      wb_q  <= 1'b0;
      xc_q  <= 1'b0;
      blk_q <= 1'b0;
      nf    <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          pb    <= postbyte;
          pc_q  <= reg_pc;
          base  <= base_in;
          old_q <= base_in;
          idx   <= 1'b0;
          ind_q <= 1'b0;
          wb_q  <= 1'b0;
          xc_q  <= 1'b0;
          nf    <= '0;
          blk_q <= blocked;
          if (blocked) begin
            ea_q <= '0;
            st   <= S_FIN;
          end else if (f_short) begin
            ea_q <= base_in + off5;
            st   <= S_FIN;
          end else if (f_auto) begin
            wbv_q <= stepped;
            ea_q  <= postbyte[4] ? base_in : stepped;
            wb_q  <= 1'b1;
            st    <= S_FIN;
          end else if (f_ind16) begin
            nf    <= 2'd2;
            ind_q <= 1'b1;
            xc_q  <= 1'b1;
            st    <= S_FETCH;
          end else if (f_off) begin
            nf   <= postbyte[1] ? 2'd2 : 2'd1;
            xc_q <= 1'b1;
            st   <= S_FETCH;
          end else if (postbyte[1:0] == 2'd3) begin
            sum   <= base_in + d_val;
            ind_q <= 1'b1;
            xc_q  <= 1'b1;
            st    <= S_IND;
          end else begin
            ea_q <= base_in + acc_off;
            st   <= S_FIN;
          end
        end
        S_FETCH: if (bus_ack) begin
          if (nf == 2'd2 && !idx) begin
            hi  <= bus_rdata;
            idx <= 1'b1;
          end else if (ind_q) begin
            sum <= base + fetch_off;
            idx <= 1'b0;
            st  <= S_IND;
          end else begin
            ea_q <= base + fetch_off;
            st   <= S_FIN;
          end
        end
        S_IND: if (bus_ack) begin
          if (!idx) begin
            hi  <= bus_rdata;
            idx <= 1'b1;
          end else begin
            ea_q <= AW'({hi, bus_rdata});
            st   <= S_FIN;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign bus_req   = (st == S_FETCH) || (st == S_IND);
  assign bus_addr  = ((st == S_IND) ? sum : pc_q) + AW'(idx);
  assign done      = (st == S_FIN);
  assign eff_addr  = ea_q;
  assign wb_en     = done && wb_q;
  assign wb_sel    = pb[7:6];
  assign wb_val    = wbv_q;
  assign ext_len   = done ? nf : 2'd0;
  assign extra_cyc = done && xc_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr)));

  // R3
  pre_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && !pb[4]) |-> (eff_addr == wb_val));

  // R3
  post_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && pb[4]) |-> (eff_addr == old_q));

  // R9
  restrict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && blk_q) |-> (eff_addr == '0 && ext_len == 2'd0 && !extra_cyc));

endmodule

// File: tb/idx_addr_gen_tb_top.sv
module idx_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  postbyte = '0;
  logic        restricted = 1'b0;
  logic [15:0] reg_x = '0, reg_y = '0, reg_sp = '0, reg_pc = '0;
  logic [7:0]  acc_a = '0, acc_b = '0;
  logic        bus_req;
  logic [15:0] bus_addr;
  logic        bus_ack = 1'b0;
  logic [7:0]  bus_rdata = '0;
  logic        done, wb_en, extra_cyc;
  logic [15:0] eff_addr, wb_val;
  logic [1:0]  wb_sel, ext_len;

  int nchk = 0, nfail = 0, acks = 0, dly = 0, wcnt = 0;

  always #4 clk = ~clk;

  idx_addr_gen #(.AW(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .postbyte(postbyte),
    .restricted(restricted), .reg_x(reg_x), .reg_y(reg_y), .reg_sp(reg_sp),
    .reg_pc(reg_pc), .acc_a(acc_a), .acc_b(acc_b), .bus_req(bus_req),
    .bus_addr(bus_addr), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .done(done), .eff_addr(eff_addr), .wb_en(wb_en), .wb_sel(wb_sel),
    .wb_val(wb_val), .ext_len(ext_len), .extra_cyc(extra_cyc));

  function automatic logic [7:0] mem(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'h3C;
  endfunction

  always @(negedge clk) begin
    if (bus_ack) bus_ack = 1'b0;
    else if (bus_req) begin
      if (wcnt >= dly) begin
        bus_ack = 1'b1;
        bus_rdata = mem(bus_addr);
        acks++;
        wcnt = 0;
      end else wcnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  task automatic run(input logic [7:0] p, input logic rs, input string cfgtag);
    logic [15:0] b, w16, e_ea, e_wbv, t, d;
    logic [1:0]  rs_code, e_len;
    logic        e_wb, e_xc;
    int          e_acks, lat;
    string       tag;
    rs_code = (p[7:5] == 3'b111) ? p[4:3] : p[7:6];
    case (rs_code)
      2'd0: b = reg_x;
      2'd1: b = reg_y;
      2'd2: b = reg_sp;
      default: b = reg_pc;
    endcase
    d = {acc_a, acc_b};
    w16 = {mem(reg_pc), mem(reg_pc + 16'd1)};
    e_wb = 0; e_wbv = 0; e_len = 0; e_xc = 0; e_acks = 0;
    if (!p[5]) begin
      tag = "R1";
      e_ea = b + (p[4] ? {11'h7FF, p[4:0]} : {11'h0, p[4:0]});
    end else if (p[7:6] != 2'b11) begin
      tag = p[4] ? "R2/R3post" : "R2/R3pre";
      t = p[3] ? {12'hFFF, p[3:0]} : {12'h0, p[3:0]} + 16'd1;
      e_wb = 1; e_wbv = b + t;
      e_ea = p[4] ? b : b + t;
    end else if (p[2:0] == 3'd3 || !p[2]) begin
      if (rs) begin
        tag = "R9"; e_ea = 0;
      end else if (p[2:0] == 3'd3) begin
        tag = "R6"; t = b + w16;
        e_ea = {mem(t), mem(t + 16'd1)}; e_len = 2; e_xc = 1; e_acks = 4;
      end else if (p[1]) begin
        tag = "R5"; e_ea = b + w16; e_len = 2; e_xc = 1; e_acks = 2;
      end else begin
        tag = "R4"; e_ea = b + {{8{p[0]}}, mem(reg_pc)};
        e_len = 1; e_xc = 1; e_acks = 1;
      end
    end else begin
      case (p[1:0])
        2'd0: begin tag = "R7"; e_ea = b + {8'h0, acc_a}; end
        2'd1: begin tag = "R7"; e_ea = b + {8'h0, acc_b}; end
        2'd2: begin tag = "R7"; e_ea = b + d; end
        default: begin
          tag = "R8"; t = b + d;
          e_ea = {mem(t), mem(t + 16'd1)}; e_xc = 1; e_acks = 2;
        end
      endcase
    end
    tag = {tag, cfgtag};
    @(negedge clk);
    postbyte = p; restricted = rs; start = 1'b1; acks = 0;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done) begin @(negedge clk); lat++; end
    chk({eff_addr, wb_en, wb_en ? wb_sel : 2'b0, wb_en ? wb_val : 16'h0, ext_len, extra_cyc} ==
        {e_ea, e_wb, e_wb ? p[7:6] : 2'b0, e_wbv, e_len, e_xc}, tag,
        $sformatf("pb=%h addr/wb/sel/val/len/xc", p),
        {eff_addr, 3'b0, wb_en, 2'b0, wb_sel, wb_val, 2'b0, ext_len, 3'b0, extra_cyc},
        {e_ea, 3'b0, e_wb, 2'b0, p[7:6], e_wbv, 2'b0, e_len, 3'b0, e_xc});
    chk(acks == e_acks, tag, $sformatf("pb=%h bus reads", p), acks, e_acks);
    if (e_acks == 0) chk(lat == 1, "R10", $sformatf("pb=%h done latency", p), lat, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R10 watchdog: actual no completion expected done");
    summary();
    $finish;
  end

  initial begin
    #3;
    chk(!done && !bus_req && !wb_en, "R12", "reset outputs", {done, bus_req, wb_en}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !bus_req && !wb_en, "R12", "after reset", {done, bus_req, wb_en}, 0);
    for (int cfg = 0; cfg < 4; cfg++) begin
      case (cfg)
        0: begin reg_x = 16'h1000; reg_y = 16'h2000; reg_sp = 16'h3000; reg_pc = 16'h4000; acc_a = 8'h12; acc_b = 8'h34; end
        1: begin reg_x = 16'hFFFE; reg_y = 16'h0003; reg_sp = 16'hFFF8; reg_pc = 16'hFFFF; acc_a = 8'hFF; acc_b = 8'h80; end
        2: begin reg_x = 16'h0000; reg_y = 16'h8000; reg_sp = 16'h7FFF; reg_pc = 16'h0001; acc_a = 8'h80; acc_b = 8'hFF; end
        default: begin reg_x = 16'hABCD; reg_y = 16'h1234; reg_sp = 16'h5678; reg_pc = 16'h9ABC; acc_a = 8'h00; acc_b = 8'h00; end
      endcase
      for (int rs = 0; rs < 2; rs++)
        for (int p = 0; p < 256; p++) begin
          dly = (p + cfg) % 3;
          run(8'(p), rs[0], (cfg == 1 || cfg == 2) ? "/R11" : "");
        end
    end
    summary();
    $finish;
  end
endmodule